// File: doc/BRIEF.md
# Ping-Pong Stereo Sample Buffer

This block gathers a stream of interleaved stereo audio words into one of two equal memory banks while a consumer reads blocks out of the other bank. Every sample strobe stores one word in the bank that is filling and advances a write pointer. That is the only work done per sample. Left words go to even addresses and right words go to odd addresses, and a frame counts only once its right word is in.

When the number of complete frames reaches the programmed block length, the banks trade roles. The write pointer returns to zero and a one-cycle ready pulse announces which bank has just become stable. The consumer then walks that bank through a synchronous read port, using its own address counter, and stops at the block length. It acknowledges each block. If a new swap arrives while the previous block is still unacknowledged, a sticky overrun flag records the loss, and the swap happens anyway.

The block length is sampled only during reset and at each swap. It is clamped to the range 1 to `MAX_FRAMES`.

Top module: `pingpong_sample_buf`

## Requirements
- R1: While reset is low and in the first cycle after it, `blk_ready_o` is 0, `overrun_o` is 0 and `stable_bank_o` is 1 (bank 0 fills first). The write pointer starts at word 0.
- R2: Each cycle with `smp_valid_i` high stores `smp_data_i` in the filling bank at the next word address. Frame k occupies address 2k (left word) and address 2k+1 (right word).
- R3: When the right word of frame number L is stored (L being the active block length), the following happens one cycle later:
  - `blk_ready_o` is high for exactly one cycle.
  - `stable_bank_o` names the bank that was just filled.
  - The next sample is stored at address 0 of the other bank.
- R4: A bank is never written while it is the stable bank. Its contents stay unchanged however many samples arrive for the other bank.
- R5: `rd_data_o` presents the word at bank `rd_bank_i`, address `rd_addr_i` one clock cycle after those inputs are sampled.
- R6: `blk_frames_i` is captured only while reset is low and at a swap. A change in the middle of a block does not alter the length of that block.
- R7: A swap that occurs while the previous block is still unacknowledged sets `overrun_o`, and the swap still takes place. A pulse on `blk_ack_i` acknowledges the block, and an acknowledge in the same cycle as the swap counts as in time. `overrun_o` then stays high until reset.
- R8: A requested length of 0 acts as 1 frame. A request above `MAX_FRAMES` acts as `MAX_FRAMES`.
- R9: Cycles with `smp_valid_i` low store nothing and do not advance the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_frames_i | input | $clog2(MAX_FRAMES+1) | Requested block length in stereo frames |
| smp_valid_i | input | 1 | Sample strobe, one word per cycle |
| smp_data_i | input | WORD_W | Incoming sample word (left and right alternate) |
| blk_ack_i | input | 1 | Consumer acknowledges the current stable block |
| rd_bank_i | input | 1 | Bank to read |
| rd_addr_i | input | $clog2(2*MAX_FRAMES) | Word address to read |
| rd_data_o | output | WORD_W | Read data, one cycle latency |
| blk_ready_o | output | 1 | One-cycle pulse when a block becomes stable |
| stable_bank_o | output | 1 | Index of the bank the consumer owns |
| overrun_o | output | 1 | Sticky flag: a block was replaced before acknowledgement |

## Verification
A wrong write pointer shows up at the read port as a word at the wrong address, or as a ready pulse earlier or later than the 2L-th sample. Both are visible within one block. A write that leaks into the stable bank shows up the next time that bank is read back after further samples, so every test reads the stable bank again after the other bank has taken writes. Errors in length capture or acknowledge tracking surface at the next swap, as a shifted ready pulse or a wrong `overrun_o`.

// File: rtl/pingpong_sample_buf.sv
module pingpong_sample_buf #(
  parameter int WORD_W     = 24,
  parameter int MAX_FRAMES = 256,
  localparam int AW = $clog2(2 * MAX_FRAMES),
  localparam int FW = $clog2(MAX_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FW-1:0]     blk_frames_i,
  input  logic              smp_valid_i,
  input  logic [WORD_W-1:0] smp_data_i,
  input  logic              blk_ack_i,
  input  logic              rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              blk_ready_o,
  output logic              stable_bank_o,
  output logic              overrun_o
);

  localparam int          SLOTS   = 2 ** (AW + 1);
  localparam logic [FW-1:0] MAX_LEN = FW'(MAX_FRAMES);

  logic [WORD_W-1:0] mem [0:SLOTS-1];
  logic              fill_bank;
  logic [AW-1:0]     wr_ptr;
  logic [FW-1:0]     active_len;
  logic [FW-1:0]     len_eff;
  logic [FW-1:0]     frame_next;
  logic              pending;
  logic              last_word;

  assign len_eff = (blk_frames_i == '0)     ? FW'(1)  :
                   (blk_frames_i > MAX_LEN) ? MAX_LEN : blk_frames_i;

  assign frame_next = FW'(wr_ptr[AW-1:1]) + FW'(1);
  assign last_word  = smp_valid_i & wr_ptr[0] & (frame_next == active_len);

  assign stable_bank_o = ~fill_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_bank   <= 1'b0;
      wr_ptr      <= '0;
      active_len  <= len_eff;
      pending     <= 1'b0;
      overrun_o   <= 1'b0;
      blk_ready_o <= 1'b0;
    end else begin
      blk_ready_o <= last_word;
      if (smp_valid_i) begin
        if (last_word) begin
          wr_ptr     <= '0;
          fill_bank  <= ~fill_bank;
          active_len <= len_eff;
        end else begin
          wr_ptr <= wr_ptr + AW'(1);
        end
      end
      if (last_word)
        pending <= 1'b1;
      else if (blk_ack_i)
        pending <= 1'b0;
      if (last_word && pending && !blk_ack_i)
        overrun_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (smp_valid_i)
      mem[{fill_bank, wr_ptr}] <= smp_data_i;
    rd_data_o <= mem[{rd_bank_i, rd_addr_i}];
  end

endmodule

// File: rtl/pingpong_sample_buf_chk.sv
module pingpong_sample_buf_chk #(
  parameter int AW = 9,
  parameter int FW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid_i,
  input logic          blk_ready_o,
  input logic          stable_bank_o,
  input logic          overrun_o,
  input logic [AW-1:0] wr_ptr,
  input logic [FW-1:0] active_len
);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready_o |=> !blk_ready_o); // R3

  AST_READY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready_o |-> $past(smp_valid_i)); // R9

  AST_BANK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && blk_ready_o) |-> (stable_bank_o != $past(stable_bank_o))); // R3

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !blk_ready_o) |-> $stable(stable_bank_o)); // R4

  AST_LEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !blk_ready_o) |-> $stable(active_len)); // R6

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    FW'(wr_ptr >> 1) < active_len); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o); // R7

endmodule

bind pingpong_sample_buf pingpong_sample_buf_chk #(.AW(AW), .FW(FW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_valid_i  (smp_valid_i),
  .blk_ready_o  (blk_ready_o),
  .stable_bank_o(stable_bank_o),
  .overrun_o    (overrun_o),
  .wr_ptr       (wr_ptr),
  .active_len   (active_len)
);

// File: tb/test_pingpong_sample_buf.sv
module test_pingpong_sample_buf;
  localparam int WORD_W = 24;
  localparam int MAXF   = 256;
  localparam int AW     = $clog2(2 * MAXF);
  localparam int FW     = $clog2(MAXF + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FW-1:0] blk_frames = FW'(4);
  logic smp_valid = 1'b0;
  logic [WORD_W-1:0] smp_data = '0;
  logic blk_ack = 1'b0;
  logic rd_bank = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [WORD_W-1:0] rd_data;
  logic blk_ready, stable_bank, overrun;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pingpong_sample_buf #(.WORD_W(WORD_W), .MAX_FRAMES(MAXF)) i_pingpong_sample_buf (
    .clk(clk), .rst_n(rst_n), .blk_frames_i(blk_frames),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .blk_ack_i(blk_ack),
    .rd_bank_i(rd_bank), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .blk_ready_o(blk_ready), .stable_bank_o(stable_bank), .overrun_o(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic do_reset(input logic [FW-1:0] len);
    @(negedge clk);
    blk_frames = len;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [WORD_W-1:0] d, input logic ack);
    smp_valid = 1'b1;
    smp_data = d;
    blk_ack = ack;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    blk_ack = 1'b0;
  endtask

  task automatic ack_pulse();
    blk_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    blk_ack = 1'b0;
  endtask

  task automatic rd(input logic bank, input int addr, output logic [WORD_W-1:0] d);
    rd_bank = bank;
    rd_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset();
    do_reset(FW'(4));
    check("R1 ready", 32'(blk_ready), 0);
    check("R1 overrun", 32'(overrun), 0);
    check("R1 stable bank", 32'(stable_bank), 1);
  endtask

  task automatic t_first_block();
    logic [WORD_W-1:0] d;
    for (int i = 0; i < 8; i++) begin
      push(WORD_W'(32'h100 + i), 1'b0);
      check("R3 ready only on last right word", 32'(blk_ready), 32'(i == 7));
    end
    check("R3 stable bank after swap", 32'(stable_bank), 0);
    check("R3 ready lasts one cycle", 32'(blk_ready), 1);
    @(negedge clk);
    check("R3 ready dropped", 32'(blk_ready), 0);
    ack_pulse();
    for (int i = 0; i < 8; i++) begin
      rd(1'b0, i, d);
      check("R2/R5 interleaved word", 32'(d), 32'h100 + i);
    end
  endtask

  task automatic t_len_change_midblock();
    logic [WORD_W-1:0] d;
    push(WORD_W'(32'h200), 1'b0);
    push(WORD_W'(32'h201), 1'b0);
    blk_frames = FW'(2);
    for (int i = 2; i < 8; i++) begin
      repeat (2) @(negedge clk);
      push(WORD_W'(32'h200 + i), 1'b0);
      check("R6/R9 swap at old length", 32'(blk_ready), 32'(i == 7));
    end
    check("R3 stable bank 1", 32'(stable_bank), 1);
    check("R7 no overrun when acked", 32'(overrun), 0);
    for (int i = 0; i < 8; i++) begin
      rd(1'b1, i, d);
      check("R9 gaps leave addresses dense", 32'(d), 32'h200 + i);
    end
    for (int i = 0; i < 8; i++) begin
      rd(1'b0, i, d);
      check("R4 bank 0 kept while bank 1 filled", 32'(d), 32'h100 + i);
    end
    ack_pulse();
  endtask

  task automatic t_new_length_and_overrun();
    logic [WORD_W-1:0] d;
    for (int i = 0; i < 4; i++) begin
      push(WORD_W'(32'h300 + i), 1'b0);
      check("R6 new length used", 32'(blk_ready), 32'(i == 3));
    end
    check("R3 stable bank 0", 32'(stable_bank), 0);
    for (int i = 0; i < 8; i++) begin
      rd(1'b1, i, d);
      check("R4 bank 1 kept", 32'(d), 32'h200 + i);
    end
    for (int i = 0; i < 4; i++) push(WORD_W'(32'h400 + i), 1'b0);
    check("R7 overrun set", 32'(overrun), 1);
    check("R7 swap still done", 32'(stable_bank), 1);
    rd(1'b1, 3, d);
    check("R7 new block stored", 32'(d), 32'h403);
    ack_pulse();
    for (int i = 0; i < 4; i++) push(WORD_W'(32'h500 + i), 1'b0);
    check("R7 overrun sticky", 32'(overrun), 1);
  endtask

  task automatic t_ack_same_cycle_and_zero_len();
    do_reset(FW'(0));
    check("R1 overrun cleared", 32'(overrun), 0);
    push(WORD_W'(32'h600), 1'b0);
    check("R8 zero length no swap on left", 32'(blk_ready), 0);
    push(WORD_W'(32'h601), 1'b0);
    check("R8 zero length acts as one frame", 32'(blk_ready), 1);
    push(WORD_W'(32'h602), 1'b0);
    push(WORD_W'(32'h603), 1'b1);
    check("R7 ack at swap is in time", 32'(overrun), 0);
    check("R3 second swap", 32'(stable_bank), 1);
  endtask

  task automatic t_clamp_high();
    int early = 0;
    do_reset('1);
    for (int i = 0; i < 2 * MAXF; i++) begin
      push(WORD_W'(i), 1'b0);
      if (i < 2 * MAXF - 1 && blk_ready) early++;
    end
    check("R8 no swap before max length", 32'(early), 0);
    check("R8 swap at max length", 32'(blk_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_first_block();
    t_len_change_midblock();
    t_new_length_and_overrun();
    t_ack_same_cycle_and_zero_len();
    t_clamp_high();
    finish_run();
  end
endmodule